// File: doc/BRIEF.md
# Converter Control-Port SPI Slave

This block is the digital control port of a multichannel sigma-delta converter, seen from a host microcontroller over SPI. The host shifts in command bytes with the clock idling low. Each bit is captured on the falling SCLK edge and each reply bit is launched on the rising edge, most significant bit first. Most opcodes are one byte long. Register reads and writes take two header bytes: the first holds the start address, the second holds the register count minus one. The data bytes follow, and the address steps up by one per byte.

Conversion results arrive on a parallel port from a separate conversion controller. Each channel value is clamped to a 24-bit two's complement word and kept as the latest result. The result is shifted out on request, or after every new sample when continuous read mode is on. Leaving continuous mode starts a guard interval counted in master-clock ticks, and opcodes that finish inside that interval are dropped. Start, stop and read-data opcodes reach the conversion controller as one-cycle strobes. A register image is presented in parallel so that the converter core can use the configuration directly.

All SPI pins are resynchronised into the `clk` domain, so SCLK must be several times slower than `clk`.

Top module: `spi_cmd_slave`

## Requirements
- R1: MOSI is captured on SCLK falling edges and MISO changes only after SCLK rising edges, MSB first. While `cs_n` is low, the first rising edge of each byte presents that byte's bit 7.
- R2: A register read is `001a_aaaa` followed by a count byte n. The next n+1 bytes return the registers from address a upward. An address of 11 or more reads 00h.
- R3: A register write is `010a_aaaa` followed by a count byte n and n+1 data bytes, written to addresses a, a+1, and so on.
- R4: Address 0 is a read-only identity register reading 53h. In address 1, bits 6:3 always read 0. In address 2, bit 7 always reads 1.
- R5: Address 8 bits 4:0 always show `lead_stat` and ignore writes. Bit 6 is writable, and bits 7 and 5 read 0.
- R6: Opcode 08h pulses `start_stb`, 0Ah pulses `stop_stb` and 12h pulses `read_stb`. Each pulse lasts one `clk` cycle.
- R7: After opcode 12h, the next 6 bytes carry the latest result. Channel 0 comes first, then channel 1, each 24 bits MSB first.
- R8: A channel value above 7FFFFFh is sent as 7FFFFFh. A value below -800000h is sent as 800000h. In-range values are sent unchanged.
- R9: Opcode 10h enters continuous mode. In this mode every `sample_valid` reloads the frame, and bytes clocked after it return the frame in the R7 layout. Every opcode except 11h is ignored.
- R10: Opcode 11h leaves continuous mode. Any opcode that completes before 4 `mclk_tick` pulses have followed it is ignored.
- R11: Raising `cs_n` discards a partial byte and returns the command decoder to idle. MISO is 0 while `cs_n` is high.
- R12: After reset, address 1 reads 02h, address 2 reads 80h and the other writable registers read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Host-to-slave serial data |
| miso | output | 1 | Slave-to-host serial data, 0 when not selected |
| mclk_tick | input | 1 | One pulse per converter master-clock cycle, paces the guard interval |
| sample_valid | input | 1 | New conversion values are present on `sample_raw` |
| sample_raw | input | NCH*RAW_W | Signed channel values before clamping, channel c at bits [c*RAW_W +: RAW_W] |
| lead_stat | input | 5 | Live electrode status bits shown in address 8 |
| start_stb | output | 1 | One-cycle start-conversion strobe |
| stop_stb | output | 1 | One-cycle stop-conversion strobe |
| read_stb | output | 1 | One-cycle read-data strobe |
| cfg_image | output | NREG*8 | Parallel view of all registers, address a at bits [8a +: 8] |

## Verification
The assertions assume that SCLK high and low phases each last well over three `clk` cycles. This keeps a synchronised rising and falling edge from landing in the same cycle, so every strobe can be traced to a completed byte. They also assume that `cs_n` is only changed while SCLK is low. The bench's SPI master holds each SCLK phase for eight `clk` cycles. It changes MOSI only when it raises SCLK, and it toggles chip select only with SCLK low and after a full settling phase. The guard interval is tested by holding `mclk_tick` low and then pulsing it a chosen number of times.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NREG      = 11;
    localparam int SAMPLE_W  = 24;
    localparam int STAT_W    = 5;
    localparam int STAT_ADDR = 8;
    localparam logic [7:0] ID_CODE   = 8'h53;
    localparam logic [7:0] STAT_MASK = 8'h1F;

    localparam logic [7:0] OP_START  = 8'h08;
    localparam logic [7:0] OP_STOP   = 8'h0A;
    localparam logic [7:0] OP_RDC_ON = 8'h10;
    localparam logic [7:0] OP_RDC_OFF= 8'h11;
    localparam logic [7:0] OP_RDATA  = 8'h12;
    localparam logic [2:0] PFX_RD    = 3'b001;
    localparam logic [2:0] PFX_WR    = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_COUNT, ST_RD, ST_WR, ST_FRAME
    } cmd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic read;
    } strobe_t;

    function automatic logic [7:0] reg_wmask(input int a);
        case (a)
            0:         return 8'h00;
            1:         return 8'h87;
            2:         return 8'h7F;
            STAT_ADDR: return 8'h40;
            default:   return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] reg_force1(input int a);
        return (a == 2) ? 8'h80 : 8'h00;
    endfunction

    function automatic logic [7:0] reg_reset(input int a);
        case (a)
            0:       return ID_CODE;
            1:       return 8'h02;
            2:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_bit
);
    logic [2:0] sclk_p;
    logic [1:0] cs_p;
    logic [1:0] mosi_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= '0;
            cs_p   <= 2'b11;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[1:0], sclk};
            cs_p   <= {cs_p[0], cs_n};
            mosi_p <= {mosi_p[0], mosi};
        end
    end

    assign sclk_rise = sclk_p[1] & ~sclk_p[2];
    assign sclk_fall = ~sclk_p[1] & sclk_p[2];
    assign cs_active = ~cs_p[1];
    assign mosi_bit  = mosi_p[1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_active,
    input  logic              mosi_bit,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              miso
);
    logic [2:0]        bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-2:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            miso      <= 1'b0;
            byte_done <= 1'b0;
            if (rst) rx_byte <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                if (bit_cnt == 3'd0) begin
                    miso  <= tx_byte[BYTE_W-1];
                    tx_sh <= tx_byte[BYTE_W-2:0];
                end else begin
                    miso  <= tx_sh[BYTE_W-2];
                    tx_sh <= {tx_sh[BYTE_W-3:0], 1'b0};
                end
            end
            if (sclk_fall) begin
                rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_bit};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh, mosi_bit};
                end
            end
        end
    end
endmodule

// File: rtl/sample_clamp.sv
module sample_clamp #(
    parameter int NCH   = 2,
    parameter int RAW_W = 26,
    parameter int OUT_W = 24
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [NCH*RAW_W-1:0] raw,
    output logic                 out_valid,
    output logic [NCH*OUT_W-1:0] result
);
    localparam logic signed [RAW_W-1:0] HI = {{(RAW_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [RAW_W-1:0] LO = {{(RAW_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [RAW_W-1:0] val;
        logic [OUT_W-1:0]        clamped;
        assign val = raw[c*RAW_W +: RAW_W];
        always_comb begin
            if (val > HI)      clamped = HI[OUT_W-1:0];
            else if (val < LO) clamped = LO[OUT_W-1:0];
            else               clamped = val[OUT_W-1:0];
        end
        always_ff @(posedge clk) begin
            if (rst)           result[(NCH-1-c)*OUT_W +: OUT_W] <= '0;
            else if (in_valid) result[(NCH-1-c)*OUT_W +: OUT_W] <= clamped;
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import spi_cmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [BYTE_W-1:0]      wdata,
    input  logic [ADDR_W-1:0]      raddr,
    input  logic [STAT_W-1:0]      stat_in,
    output logic [BYTE_W-1:0]      rdata,
    output logic [NREG*BYTE_W-1:0] image
);
    localparam int SLOTS = 2 ** ADDR_W;

    logic [BYTE_W-1:0] view [SLOTS];

    for (genvar a = 0; a < SLOTS; a++) begin : g_reg
        if (a < NREG) begin : g_real
            localparam logic [BYTE_W-1:0] WM = reg_wmask(a);
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reg_reset(a);
                else if (we && waddr == ADDR_W'(a))
                    q <= (wdata & WM) | (q & ~WM) | reg_force1(a);
            end
            if (a == STAT_ADDR) begin : g_stat
                assign view[a] = (q & ~STAT_MASK) | {{(BYTE_W-STAT_W){1'b0}}, stat_in};
            end else begin : g_plain
                assign view[a] = q;
            end
            assign image[a*BYTE_W +: BYTE_W] = view[a];
        end else begin : g_none
            assign view[a] = '0;
        end
    end

    assign rdata = view[raddr];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int RAW_W     = 26,
    parameter int GAP_TICKS = 4
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   mosi,
    output logic                   miso,
    input  logic                   mclk_tick,
    input  logic                   sample_valid,
    input  logic [NCH*RAW_W-1:0]   sample_raw,
    input  logic [STAT_W-1:0]      lead_stat,
    output logic                   start_stb,
    output logic                   stop_stb,
    output logic                   read_stb,
    output logic [NREG*BYTE_W-1:0] cfg_image
);
    localparam int FRAME_W     = NCH * SAMPLE_W;
    localparam int FRAME_BYTES = FRAME_W / BYTE_W;
    localparam int IDX_W       = $clog2(FRAME_BYTES + 1);
    localparam int GAP_W       = $clog2(GAP_TICKS + 1);

    logic              sclk_rise, sclk_fall, cs_active, mosi_bit;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte, tx_src, rf_rd, frame_byte;
    logic              res_valid;
    logic [FRAME_W-1:0] result, frame_buf, frame_sh;

    cmd_state_e        state;
    logic              wr_mode, rdc;
    logic [GAP_W-1:0]  gap_cnt;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] cnt;
    logic [IDX_W-1:0]  frame_idx;
    strobe_t           stb;
    logic              rf_we;

    spi_edge_sync u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .mosi_bit(mosi_bit)
    );

    spi_byte_shifter u_shift (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .mosi_bit(mosi_bit), .tx_byte(tx_src),
        .rx_byte(rx_byte), .byte_done(byte_done), .miso(miso)
    );

    sample_clamp #(.NCH(NCH), .RAW_W(RAW_W), .OUT_W(SAMPLE_W)) u_clamp (
        .clk(clk), .rst(rst), .in_valid(sample_valid), .raw(sample_raw),
        .out_valid(res_valid), .result(result)
    );

    assign rf_we = cs_active && byte_done && (state == ST_WR);

    cfg_reg_bank u_regs (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(addr), .wdata(rx_byte),
        .raddr(addr), .stat_in(lead_stat), .rdata(rf_rd), .image(cfg_image)
    );

    // Frame bytes leave from the top; an index past the end shifts to zero.
    assign frame_sh   = frame_buf << {frame_idx, 3'b000};
    assign frame_byte = frame_sh[FRAME_W-1 -: BYTE_W];

    always_comb begin
        if (rdc || state == ST_FRAME) tx_src = frame_byte;
        else if (state == ST_RD)      tx_src = rf_rd;
        else                          tx_src = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wr_mode   <= 1'b0;
            rdc       <= 1'b0;
            gap_cnt   <= '0;
            addr      <= '0;
            cnt       <= '0;
            frame_buf <= '0;
            frame_idx <= '0;
            stb       <= '0;
        end else begin
            stb <= '0;
            if (gap_cnt != '0 && mclk_tick) gap_cnt <= gap_cnt - 1'b1;

            if (!cs_active) begin
                state     <= ST_IDLE;
                frame_idx <= '0;
            end else if (byte_done) begin
                unique case (state)
                    ST_IDLE: if (gap_cnt == '0) begin
                        if (rdc) begin
                            if (rx_byte == OP_RDC_OFF) begin
                                rdc     <= 1'b0;
                                gap_cnt <= GAP_W'(GAP_TICKS);
                            end else if (frame_idx != IDX_W'(FRAME_BYTES)) begin
                                frame_idx <= frame_idx + 1'b1;
                            end
                        end else if (rx_byte[7:5] == PFX_RD || rx_byte[7:5] == PFX_WR) begin
                            addr    <= rx_byte[ADDR_W-1:0];
                            wr_mode <= (rx_byte[7:5] == PFX_WR);
                            state   <= ST_COUNT;
                        end else begin
                            case (rx_byte)
                                OP_START:   stb.start <= 1'b1;
                                OP_STOP:    stb.stop  <= 1'b1;
                                OP_RDATA: begin
                                    stb.read  <= 1'b1;
                                    frame_buf <= result;
                                    frame_idx <= '0;
                                    state     <= ST_FRAME;
                                end
                                OP_RDC_ON: begin
                                    rdc       <= 1'b1;
                                    frame_buf <= result;
                                    frame_idx <= '0;
                                end
                                OP_RDC_OFF: gap_cnt <= GAP_W'(GAP_TICKS);
                                default: ;
                            endcase
                        end
                    end
                    ST_COUNT: begin
                        cnt   <= rx_byte;
                        state <= wr_mode ? ST_WR : ST_RD;
                    end
                    ST_RD, ST_WR: begin
                        addr <= addr + 1'b1;
                        if (cnt == '0) state <= ST_IDLE;
                        else           cnt   <= cnt - 1'b1;
                    end
                    ST_FRAME: begin
                        frame_idx <= frame_idx + 1'b1;
                        if (frame_idx == IDX_W'(FRAME_BYTES - 1)) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end

            if (rdc && res_valid) begin
                frame_buf <= result;
                frame_idx <= '0;
            end
        end
    end

    assign start_stb = stb.start;
    assign stop_stb  = stb.stop;
    assign read_stb  = stb.read;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk
    import spi_cmd_pkg::*;
#(
    parameter int GAP_W = 3
)(
    input logic             clk,
    input logic             rst,
    input logic             cs_active,
    input logic             byte_done,
    input cmd_state_e       state,
    input logic [GAP_W-1:0] gap_cnt,
    input strobe_t          stb,
    input logic             miso
);
    // R6: strobes never overlap
    assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.start, stb.stop, stb.read}));

    // R6: a strobe is always the cycle after a completed byte
    assert_strobe_after_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (stb.start || stb.stop || stb.read) |-> $past(byte_done));

    // R10: a byte finishing inside the guard interval has no effect
    assert_gap_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (cs_active && byte_done && gap_cnt != '0 && state == ST_IDLE)
        |=> (!stb.start && !stb.stop && !stb.read && state == ST_IDLE));

    // R11: deselect forces the decoder idle and the data line low
    assert_deselect_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> (state == ST_IDLE && !miso));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.GAP_W(GAP_W)) u_chk (
    .clk(clk), .rst(rst), .cs_active(cs_active), .byte_done(byte_done),
    .state(state), .gap_cnt(gap_cnt), .stb(stb), .miso(miso)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
    localparam int RAW_W = 26;
    localparam int H     = 8;

    logic clk = 1'b0;
    logic rst, sclk, cs_n, mosi, miso, mclk_tick, sample_valid;
    logic [2*RAW_W-1:0] sample_raw;
    logic [4:0]  lead_stat;
    logic start_stb, stop_stb, read_stb;
    logic [87:0] cfg_image;

    always #5 clk = ~clk;

    spi_cmd_slave u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .mclk_tick(mclk_tick), .sample_valid(sample_valid), .sample_raw(sample_raw),
        .lead_stat(lead_stat), .start_stb(start_stb), .stop_stb(stop_stb),
        .read_stb(read_stb), .cfg_image(cfg_image)
    );

    typedef struct {
        bit         chk;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t expq[$];
    logic [7:0] rx_last;
    event rx_ev;
    int vectors = 0, fails = 0;
    int n_start = 0, n_stop = 0, n_read = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // scoreboard monitor: compares each received byte with the queued expectation
    initial begin
        forever begin
            @(rx_ev);
            if (expq.size() != 0) begin
                exp_t e;
                e = expq.pop_front();
                if (e.chk) check(e.tag, {24'h0, rx_last}, {24'h0, e.exp});
            end
        end
    end

    always @(posedge clk) begin
        if (start_stb) n_start++;
        if (stop_stb)  n_stop++;
        if (read_stb)  n_read++;
    end

    task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        exp_t e;
        e.chk = chk; e.exp = exp; e.tag = tag;
        expq.push_back(e);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk); sclk = 1'b1; mosi = tx[b];
            repeat (H) @(negedge clk);
            got[b] = miso;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        rx_last = got;
        -> rx_ev;
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic desel();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel(); xfer(op, 0, 8'h00, ""); desel();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mclk_tick = 1'b1;
            @(negedge clk); mclk_tick = 1'b0;
        end
    endtask

    function automatic logic [23:0] clamp24(input int v);
        if (v > 8388607)   return 24'h7FFFFF;
        if (v < -8388608)  return 24'h800000;
        return v[23:0];
    endfunction

    task automatic push_sample(input int v0, input int v1);
        @(negedge clk);
        sample_raw   = {v1[RAW_W-1:0], v0[RAW_W-1:0]};
        sample_valid = 1'b1;
        @(negedge clk); sample_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [47:0] f;
        rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; mclk_tick = 1'b0;
        sample_valid = 1'b0; sample_raw = '0; lead_stat = 5'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R12 reset state at the ports
        check("R12 miso idle", {31'h0, miso}, 32'h0);
        check("R12 strobes idle", {29'h0, start_stb, stop_stb, read_stb}, 32'h0);
        check("R12 image 1..0", {16'h0, cfg_image[15:0]}, 32'h0253);
        check("R12 image 2", {24'h0, cfg_image[23:16]}, 32'h80);

        // R2 R12 burst read from 0
        sel(); xfer(8'h20, 0, 0, ""); xfer(8'h03, 0, 0, "");
        xfer(8'h00, 1, 8'h53, "R2 R4 id");
        xfer(8'h00, 1, 8'h02, "R1 R12 cfg1 reset");
        xfer(8'h00, 1, 8'h80, "R12 cfg2 reset");
        xfer(8'h00, 1, 8'h00, "R12 addr3 reset");
        desel();

        // R3 burst write, then R2 burst read back
        sel(); xfer(8'h43, 0, 0, ""); xfer(8'h02, 0, 0, "");
        xfer(8'hA5, 0, 0, ""); xfer(8'h5A, 0, 0, ""); xfer(8'h3C, 0, 0, ""); desel();
        sel(); xfer(8'h23, 0, 0, ""); xfer(8'h02, 0, 0, "");
        xfer(8'h00, 1, 8'hA5, "R3 addr3"); xfer(8'h00, 1, 8'h5A, "R3 addr4");
        xfer(8'h00, 1, 8'h3C, "R3 addr5"); desel();

        // R4 field rules
        sel(); xfer(8'h41, 0, 0, ""); xfer(8'h01, 0, 0, "");
        xfer(8'hFF, 0, 0, ""); xfer(8'h00, 0, 0, ""); desel();
        sel(); xfer(8'h40, 0, 0, ""); xfer(8'h00, 0, 0, ""); xfer(8'h00, 0, 0, ""); desel();
        sel(); xfer(8'h20, 0, 0, ""); xfer(8'h02, 0, 0, "");
        xfer(8'h00, 1, 8'h53, "R4 id write ignored");
        xfer(8'h00, 1, 8'h87, "R4 cfg1 zero bits");
        xfer(8'h00, 1, 8'h80, "R4 cfg2 forced one"); desel();
        check("R4 image cfg1", {24'h0, cfg_image[15:8]}, 32'h87);

        // R5 status bits
        lead_stat = 5'b10101;
        sel(); xfer(8'h48, 0, 0, ""); xfer(8'h00, 0, 0, ""); xfer(8'hFF, 0, 0, ""); desel();
        sel(); xfer(8'h28, 0, 0, ""); xfer(8'h00, 0, 0, "");
        xfer(8'h00, 1, 8'h55, "R5 status read-only"); desel();

        // R2 past the end of the map
        sel(); xfer(8'h4A, 0, 0, ""); xfer(8'h00, 0, 0, ""); xfer(8'h77, 0, 0, ""); desel();
        sel(); xfer(8'h2A, 0, 0, ""); xfer(8'h01, 0, 0, "");
        xfer(8'h00, 1, 8'h77, "R2 last addr"); xfer(8'h00, 1, 8'h00, "R2 unmapped"); desel();

        // R6 strobes
        cmd1(8'h08);
        check("R6 start count", n_start, 1);
        cmd1(8'h0A);
        check("R6 stop count", n_stop, 1);

        // R7 R8 saturation through RDATA
        push_sample(16777216, -16777216);
        f = {clamp24(16777216), clamp24(-16777216)};
        sel(); xfer(8'h12, 0, 0, "");
        for (int i = 0; i < 6; i++) xfer(8'h00, 1, f[47-8*i -: 8], "R8 saturated frame");
        desel();
        check("R6 read count", n_read, 1);
        push_sample(32'h012345, -5);
        f = {clamp24(32'h012345), clamp24(-5)};
        sel(); xfer(8'h12, 0, 0, "");
        for (int i = 0; i < 6; i++) xfer(8'h00, 1, f[47-8*i -: 8], "R7 in-range frame");
        desel();

        // R9 continuous mode, other opcodes ignored
        cmd1(8'h10);
        push_sample(32'h000100, 8388607);
        f = {clamp24(32'h000100), clamp24(8388607)};
        sel();
        xfer(8'h08, 1, f[47:40], "R9 frame b0");
        xfer(8'h21, 1, f[39:32], "R9 frame b1");
        for (int i = 2; i < 6; i++) xfer(8'h00, 1, f[47-8*i -: 8], "R9 frame");
        desel();
        check("R9 start ignored", n_start, 1);
        push_sample(-1, 8388608);
        f = {clamp24(-1), clamp24(8388608)};
        sel();
        for (int i = 0; i < 6; i++) xfer(8'h00, 1, f[47-8*i -: 8], "R9 R8 reloaded frame");
        desel();

        // R10 guard interval
        sel(); xfer(8'h11, 0, 0, ""); xfer(8'h08, 0, 0, ""); desel();
        check("R10 start inside gap", n_start, 1);
        ticks(3);
        cmd1(8'h08);
        check("R10 start after 3 ticks", n_start, 1);
        ticks(1);
        cmd1(8'h08);
        check("R10 start after 4 ticks", n_start, 2);
        sel(); xfer(8'h12, 0, 0, "");
        xfer(8'h00, 1, 8'hFF, "R10 continuous off, RDATA works");
        for (int i = 1; i < 6; i++) xfer(8'h00, 0, 0, "");
        desel();

        // R11 abort mid-byte
        sel();
        for (int b = 0; b < 5; b++) begin
            @(negedge clk); sclk = 1'b1; mosi = 1'b0;
            repeat (H) @(negedge clk); sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        desel();
        check("R11 miso low deselected", {31'h0, miso}, 32'h0);
        sel(); xfer(8'h23, 0, 0, ""); xfer(8'h00, 0, 0, "");
        xfer(8'h00, 1, 8'hA5, "R11 clean after abort"); desel();

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule